// File: doc/BRIEF.md
# Auxiliary Device Interrupt Latch

This block sits between a shared interrupt pin and the interrupt controller's level-12 request line. The pin can serve in two ways. As a plain IRQ12 line, it is synchronised and passed straight through. As a pointing-device interrupt, a low-to-high change on the synchronised pin sets a held request toward the interrupt controller. That request stays up until the CPU reads the data port at I/O address 0x60. A configuration enable bit, `mouse_mode_i`, chooses between the two uses.

The block watches a simple I/O strobe interface made of an address, a read strobe and a write strobe. Any access to port 0x60, in either mode, raises a forward flag so that the surrounding logic passes the cycle on to the external I/O bus. The keyboard controller on that bus is outside this block.

The controller has three named states. ST_PASS is pass-through mode: the output follows the synchronised pin. ST_IDLE is mouse mode with no request held, so the output is low. ST_PENDING is mouse mode with a request held, so the output is high.

The transitions are:
- `pass_to_idle` when the enable bit is set while in ST_PASS.
- `idle_to_pass` and `pend_to_pass` when the enable bit clears.
- `idle_to_pend` on a rising edge of the synchronised pin.
- `pend_to_idle` on a read of port 0x60 with no rising edge in the same cycle.
- `pend_hold` in every other ST_PENDING case.

Reset enters ST_IDLE.

Top module: `aux_irq_latch`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `irq12_o` is low and the block is in ST_IDLE.
- R2: With `mouse_mode_i` low, `irq12_o` equals the value `irq_pin_i` had SYNC_STAGES (default 2) rising clock edges earlier.
- R3: With `mouse_mode_i` high, a low-to-high change of the synchronised pin sets `irq12_o` high one clock after the edge is seen. The output stays high after the pin falls.
- R4: With `mouse_mode_i` high, a cycle with `io_rd_i` high and `io_addr_i` equal to 0x60 clears a held request at the next clock edge.
- R5: A write to 0x60 never clears the held request, and neither does a read of any other address.
- R6: With `mouse_mode_i` low, reads of 0x60 have no effect on `irq12_o`.
- R7: If a rising edge and a 0x60 read fall in the same cycle, the request ends up set.
- R8: Any change of `mouse_mode_i` discards a held request. Returning to mouse mode starts in ST_IDLE with `irq12_o` low.
- R9: `ext_fwd_o` is high in exactly those cycles where `io_rd_i` or `io_wr_i` is high and `io_addr_i` is 0x60, in either mode. It is combinational, with no added latency.
- R10: A pin held high does not set the request again after a release. Only a new low-to-high change does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mouse_mode_i | input | 1 | 1 = held pointing-device interrupt, 0 = plain IRQ12 pass-through |
| irq_pin_i | input | 1 | Shared interrupt pin, asynchronous, active high |
| io_addr_i | input | ADDR_W (16) | I/O cycle address |
| io_rd_i | input | 1 | I/O read strobe, one cycle per access |
| io_wr_i | input | 1 | I/O write strobe, one cycle per access |
| irq12_o | output | 1 | Request toward the interrupt controller |
| ext_fwd_o | output | 1 | Current access to port 0x60 is forwarded to the external bus |

## Verification
The hardest case to reach from the ports is the R7 collision. In that case the port read must land in the exact cycle where the synchroniser delivers the edge, which is SYNC_STAGES clocks after the pin moves. The stimulus first sets and holds a request. It then drops the pin, raises it again, waits exactly two clocks and issues the read, so that the edge and the read meet in that cycle. A second collision starts from an empty latch. The reference model tracks the pin's delay line on its own, so an off-by-one in the synchroniser shows up as a mismatch in every cycle.

// File: rtl/aux_irq_pkg.sv
package aux_irq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PENDING = 2'd1,
        ST_PASS    = 2'd2
    } aux_state_e;
endpackage

// File: rtl/aux_irq_sync.sv
module aux_irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q <= '0;
                else         chain_q <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q <= '0;
                else         chain_q <= {chain_q[LAST-1:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[LAST];
endmodule

// File: rtl/aux_irq_port_decode.sv
module aux_irq_port_decode #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] PORT_ADDR = 16'h0060
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    output logic              rd_hit_o,
    output logic              fwd_o
);
    localparam logic [ADDR_W-1:0] MATCH = PORT_ADDR[ADDR_W-1:0];

    logic hit;

    always_comb begin
        hit      = (addr_i == MATCH);
        rd_hit_o = hit && rd_i;
        fwd_o    = hit && (rd_i || wr_i);
    end
endmodule

// File: rtl/aux_irq_fsm.sv
module aux_irq_fsm
    import aux_irq_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       mode_i,
    input  logic       pin_sync_i,
    input  logic       rd_hit_i,
    output logic       irq_o,
    output aux_state_e state_o
);
    aux_state_e state_q, state_d;
    logic       prev_q;
    logic       rise;

    assign rise = pin_sync_i && !prev_q;

    // Edge-detect history register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= pin_sync_i;
    end

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PASS: begin
                if (mode_i) state_d = ST_IDLE;            // pass_to_idle
            end
            ST_IDLE: begin
                if (!mode_i)   state_d = ST_PASS;         // idle_to_pass
                else if (rise) state_d = ST_PENDING;      // idle_to_pend
            end
            ST_PENDING: begin
                if (!mode_i)                 state_d = ST_PASS;  // pend_to_pass
                else if (rd_hit_i && !rise)  state_d = ST_IDLE;  // pend_to_idle
                // otherwise pend_hold
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // Output decode.
    always_comb begin
        unique case (state_q)
            ST_PASS:    irq_o = pin_sync_i;
            ST_PENDING: irq_o = 1'b1;
            default:    irq_o = 1'b0;
        endcase
    end

    assign state_o = state_q;

    // R4: a matching read releases a held request when no edge collides.
    a_r4_read_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_PENDING && mode_i && rd_hit_i && !rise) |=> (state_q == ST_IDLE && !irq_o));

    // R7: a rising edge in mouse mode always leaves the request set.
    a_r7_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != ST_PASS && mode_i && rise) |=> (state_q == ST_PENDING && irq_o));

    // R5: without a matching read the request is held.
    a_r5_hold_without_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_PENDING && mode_i && !rd_hit_i) |=> irq_o);

    // R8: leaving mouse mode discards any request.
    a_r8_mode_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != ST_PASS && !mode_i) |=> (state_q == ST_PASS));

    // R8: re-entering mouse mode starts with no request.
    a_r8_mode_enter: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_PASS && mode_i) |=> (state_q == ST_IDLE && !irq_o));
endmodule

// File: rtl/aux_irq_latch.sv
module aux_irq_latch
    import aux_irq_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter logic [15:0] PORT_ADDR   = 16'h0060,
    parameter int          SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              mouse_mode_i,
    input  logic              irq_pin_i,
    input  logic [ADDR_W-1:0] io_addr_i,
    input  logic              io_rd_i,
    input  logic              io_wr_i,
    output logic              irq12_o,
    output logic              ext_fwd_o
);
    logic       pin_sync;
    logic       rd_hit;
    aux_state_e state;

    aux_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (irq_pin_i),
        .q_o    (pin_sync)
    );

    aux_irq_port_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_dec (
        .addr_i   (io_addr_i),
        .rd_i     (io_rd_i),
        .wr_i     (io_wr_i),
        .rd_hit_o (rd_hit),
        .fwd_o    (ext_fwd_o)
    );

    aux_irq_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .mode_i     (mouse_mode_i),
        .pin_sync_i (pin_sync),
        .rd_hit_i   (rd_hit),
        .irq_o      (irq12_o),
        .state_o    (state)
    );

    // R6: in pass-through mode the output is the synchronised pin, reads or not.
    a_r6_pass_follows_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_PASS) |-> (irq12_o == pin_sync));
endmodule

// File: tb/aux_irq_latch_tb_top.sv
module aux_irq_latch_tb_top;
    localparam int          ADDR_W = 16;
    localparam int          STAGES = 2;
    localparam logic [15:0] PORT   = 16'h0060;

    logic              clk = 1'b0;
    logic              rst_ni = 1'b0;
    logic              mode = 1'b0;
    logic              pin = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              rd = 1'b0;
    logic              wr = 1'b0;
    logic              irq12, fwd;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";
    bit    done     = 1'b0;

    always #2.5 clk = ~clk;

    aux_irq_latch #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT), .SYNC_STAGES(STAGES)) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_ni),
        .mouse_mode_i (mode),
        .irq_pin_i    (pin),
        .io_addr_i    (addr),
        .io_rd_i      (rd),
        .io_wr_i      (wr),
        .irq12_o      (irq12),
        .ext_fwd_o    (fwd)
    );

    // Behavioural reference model.
    bit hist[$];
    bit m_sync, m_prev, m_held, m_pass;

    always @(posedge clk) begin
        if (!rst_ni) begin
            hist.delete();
            m_sync = 0; m_prev = 0; m_held = 0; m_pass = 0;
        end else begin
            bit edge_seen, port_rd;
            edge_seen = m_sync && !m_prev;
            port_rd   = rd && (addr == PORT[ADDR_W-1:0]);
            if (m_pass) begin
                if (mode) begin m_pass = 0; m_held = 0; end
            end else if (!mode) begin
                m_pass = 1; m_held = 0;
            end else if (edge_seen) begin
                m_held = 1;
            end else if (port_rd) begin
                m_held = 0;
            end
            m_prev = m_sync;
            hist.push_back(pin);
            if (hist.size() > STAGES) void'(hist.pop_front());
            m_sync = (hist.size() == STAGES) ? hist[0] : 1'b0;
        end
    end

    task automatic check(string req, logic act, logic exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (!done) begin
            logic exp_irq, exp_fwd;
            exp_irq = (!rst_ni) ? 1'b0 : (m_pass ? m_sync : m_held);
            exp_fwd = (rd || wr) && (addr == PORT[ADDR_W-1:0]);
            check(cur_req, irq12, exp_irq, "irq12_o");
            check("R9", fwd, exp_fwd, "ext_fwd_o");
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic io_cycle(logic [ADDR_W-1:0] a, logic r, logic w);
        addr = a; rd = r; wr = w;
        step(1);
        rd = 0; wr = 0; addr = '0;
    endtask

    task automatic at_negedge_check(string req, logic exp);
        @(negedge clk);
        check(req, irq12, exp, "directed irq12_o");
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        #(5 * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : stim
        // R1 reset
        cur_req = "R1";
        mode = 1'b1;
        step(3);
        @(negedge clk);
        check("R1", irq12, 1'b0, "in reset");
        rst_ni = 1'b1;
        @(posedge clk);
        #1;
        at_negedge_check("R1", 1'b0);

        // R3 set in mouse mode; pin pulse then falls
        cur_req = "R3";
        pin = 1; step(2); pin = 0;
        step(4);
        at_negedge_check("R3", 1'b1);

        // R5 write to 0x60 and read of another port keep the request
        cur_req = "R5";
        io_cycle(16'h0060, 1'b0, 1'b1);
        io_cycle(16'h0064, 1'b1, 1'b0);
        io_cycle(16'h0160, 1'b1, 1'b0);
        step(2);
        at_negedge_check("R5", 1'b1);

        // R4 read releases
        cur_req = "R4";
        io_cycle(16'h0060, 1'b1, 1'b0);
        step(1);
        at_negedge_check("R4", 1'b0);

        // R10 level held high does not re-set
        cur_req = "R10";
        pin = 1; step(5);
        io_cycle(16'h0060, 1'b1, 1'b0);
        step(5);
        at_negedge_check("R10", 1'b0);
        pin = 0; step(3);
        pin = 1; step(4);
        at_negedge_check("R10", 1'b1);

        // R7 edge and read collide while a request is held
        cur_req = "R7";
        pin = 0; step(3);
        pin = 1; step(2);
        io_cycle(16'h0060, 1'b1, 1'b0);
        step(1);
        at_negedge_check("R7", 1'b1);
        // clear then collide from empty latch
        pin = 0;
        io_cycle(16'h0060, 1'b1, 1'b0);
        step(3);
        pin = 1; step(2);
        io_cycle(16'h0060, 1'b1, 1'b0);
        step(1);
        at_negedge_check("R7", 1'b1);

        // R8 mode change drops the request
        cur_req = "R8";
        pin = 0; step(3);
        mode = 0; step(2);
        mode = 1; step(2);
        at_negedge_check("R8", 1'b0);
        pin = 1; step(4);
        pin = 0; step(3);
        mode = 0; step(1);
        mode = 1; step(2);
        at_negedge_check("R8", 1'b0);

        // R2 pass-through follows pin
        cur_req = "R2";
        mode = 0; step(3);
        pin = 1; step(3);
        at_negedge_check("R2", 1'b1);
        pin = 0; step(1); pin = 1; step(1); pin = 0; step(1); pin = 1;
        step(4);

        // R6 reads of 0x60 have no effect in pass-through
        cur_req = "R6";
        io_cycle(16'h0060, 1'b1, 1'b0);
        io_cycle(16'h0060, 1'b1, 1'b1);
        at_negedge_check("R6", 1'b1);
        pin = 0; step(3);
        io_cycle(16'h0060, 1'b1, 1'b0);
        at_negedge_check("R6", 1'b0);

        // R9 forwarding in both modes
        cur_req = "R9";
        io_cycle(16'h0060, 1'b0, 1'b1);
        mode = 1; step(2);
        io_cycle(16'h0060, 1'b0, 1'b1);
        io_cycle(16'h0061, 1'b1, 1'b1);
        step(2);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule